// File: doc/BRIEF.md
# SPI Memory Bridge Target

This block sits on the device side of a serial link. It turns host transactions, delivered one byte at a time, into accesses on a local 32-bit synchronous memory port with byte enables. Each frame opens with a command byte and a four-byte address, most significant byte first. A write frame then carries data words and ends with one throwaway byte. A read frame carries four filler bytes and then the block streams memory contents back to the host.

Three access widths exist: half-word (2 wire bytes per word), word (4 bytes) and double word (8 bytes). Each wire word travels most significant byte first and lands in little-endian memory. The address advances by the word size after every completed word. Double-word frames are capped at 240 data bytes. Half-word accesses are legal only inside one fixed address window. Accesses outside it are dropped and raise an error flag.

The byte source must leave at least five clock cycles between accepted bytes, so that a read word can be fetched in time. Addresses are assumed aligned to the access width.

Top module: `spi_mem_bridge`

## Requirements
- R1: The command byte selects the access: 0x00 half read, 0x01 half write, 0x02 word read, 0x03 word write, 0x04 double read, 0x05 double write. Any other value makes the rest of the frame ignored: no memory access, and tx_byte stays 0x00.
- R2: The four bytes after the command form the start address, most significant byte first.
- R3: In a read frame, the four bytes after the address are filler and tx_byte is 0x00 during them. Read data starts on the tenth byte of the frame.
- R4: A word write commits after its 4th data byte as one memory write: mem_addr equal to the address, mem_be=4'b1111, mem_wdata equal to the four bytes taken as a big-endian value.
- R5: A half write commits after its 2nd byte. With V the two bytes taken as a big-endian value, mem_wdata={V,V}, mem_be=4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1, and mem_addr has its two low bits cleared.
- R6: A double write commits after its 8th byte, with V the eight bytes as a big-endian value. It writes V[31:0] to the address in one cycle and V[63:32] to the address plus 4 in the next cycle, both with mem_be=4'b1111.
- R7: A double read sends the word at the address plus 4 first, then the word at the address, each most significant byte first.
- R8: After each completed word the access address advances by the word size (2, 4 or 8).
- R9: Bytes of a write word left incomplete when frame_act falls are discarded. This includes the trailing throwaway byte, so it never reaches memory.
- R10: In a double frame only the first 240 data bytes count. Later write bytes are ignored, and later read bytes return 0x00.
- R11: A half access is legal for addresses from 0x18020000 up to but excluding 0x18021000. Outside that range a half write produces no memory write, a half read returns 0x00 bytes without a memory read, and win_err is set.
- R12: win_err is 0 after reset. It is cleared when the next valid command byte is accepted.
- R13: Dropping frame_act at any point returns the block to waiting for a command, and the next frame decodes normally.
- R14: A word read sends the memory word most significant byte first. A half read sends bits [31:16] when address bit 1 is 1 and bits [15:0] when it is 0, most significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_act | input | 1 | High while a host frame is open |
| rx_valid | input | 1 | One-cycle pulse: a byte has been exchanged |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte sent to the host in the slot marked by rx_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data, lane 0 in bits [7:0] |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| win_err | output | 1 | Half access fell outside its legal window |

## Verification
The bench targets the byte-order corners. A double write whose halves were swapped would put the first four bytes at the base address rather than at base plus 4. A half access to lane pair 1 would show the wrong byte enables or the wrong half of the read word. It ends write frames with a throwaway byte and cuts frames inside a word, so a design that committed partial words would issue a write nobody expects. It also runs a double frame past 240 bytes, plays half accesses just outside the window, sends an undefined command, and drops a frame in the middle of the address. A design that did not return to command wait would misparse the following frame.

// File: rtl/spib_pkg.sv
// Shared types and helpers for the SPI memory bridge target.
// Assumes: 32-bit addresses and a 32-bit little-endian memory port.
package spib_pkg;

    // Access width, encoded as bits [2:1] of the command byte.
    typedef enum logic [1:0] {
        K_HALF  = 2'd0,
        K_WORD  = 2'd1,
        K_BURST = 2'd2
    } xfer_kind_t;

    // Position inside a frame.
    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_t;

    // Number of wire bytes that make up one data word of the given kind.
    function automatic logic [3:0] kind_bytes(input xfer_kind_t k);
        case (k)
            K_HALF:  return 4'd2;
            K_WORD:  return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // Half-access window check: lo inclusive, hi exclusive.
    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/spib_frame_dec.sv
// Frame decoder: parses the command byte and the address, skips the read
// filler bytes, and marks the data phase. It also counts data bytes so that
// double frames stop at BURST_MAX.
// Assumes: rx_valid is a single-cycle pulse and is only seen while frame_act is high.
module spib_frame_dec
    import spib_pkg::*;
#(
    parameter int BURST_MAX = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_act,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output xfer_kind_t       kind,
    output logic             is_write,
    output logic [31:0]      base_addr,
    output logic             addr_done,
    output logic             cmd_start,
    output logic             in_data,
    output logic             data_ok,
    output logic             data_stb
);
    localparam int CNT_W = $clog2(BURST_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(BURST_MAX);
    localparam logic [7:0] CMD_LAST = 8'd5;

    phase_t           phase;
    logic [1:0]       cnt;
    logic [CNT_W-1:0] data_cnt;

    // Frame phase sequencing, command/address capture and data byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            data_cnt  <= '0;
            kind      <= K_HALF;
            is_write  <= 1'b0;
            base_addr <= '0;
            addr_done <= 1'b0;
            cmd_start <= 1'b0;
        end else if (!frame_act) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            data_cnt  <= '0;
            addr_done <= 1'b0;
            cmd_start <= 1'b0;
        end else begin
            addr_done <= 1'b0;
            cmd_start <= 1'b0;
            if (rx_valid) begin
                case (phase)
                    PH_CMD: begin
                        if (rx_byte <= CMD_LAST) begin
                            kind      <= xfer_kind_t'(rx_byte[2:1]);
                            is_write  <= rx_byte[0];
                            phase     <= PH_ADDR;
                            cnt       <= '0;
                            cmd_start <= 1'b1;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        base_addr <= {base_addr[23:0], rx_byte};
                        cnt       <= cnt + 2'd1;
                        if (cnt == 2'd3) begin
                            addr_done <= 1'b1;
                            data_cnt  <= '0;
                            phase     <= is_write ? PH_DATA : PH_DUMMY;
                        end
                    end
                    PH_DUMMY: begin
                        cnt <= cnt + 2'd1;
                        if (cnt == 2'd3) phase <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (data_cnt < CNT_CAP) data_cnt <= data_cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Data-phase qualifiers seen by both data paths.
    always_comb begin
        in_data  = frame_act && (phase == PH_DATA);
        data_ok  = !((kind == K_BURST) && (data_cnt == CNT_CAP));
        data_stb = in_data && rx_valid && data_ok;
    end

    // R13: a closed frame never leaves the decoder in the data phase
    p_cmd_wait_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> !in_data);

endmodule

// File: rtl/spib_wr_path.sv
// Write path: shifts incoming data bytes into a word, and once the word is
// complete turns it into one or two little-endian memory writes. The half
// window is checked at commit time. A word left incomplete at frame end is
// discarded.
// Assumes: data strobes are at least 2 cycles apart, so the second half of a
// double word has left before the next word can complete.
module spib_wr_path
    import spib_pkg::*;
#(
    parameter logic [31:0] WIN_LO = 32'h1802_0000,
    parameter logic [31:0] WIN_HI = 32'h1802_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_act,
    input  logic        active,
    input  xfer_kind_t  kind,
    input  logic        addr_done,
    input  logic [31:0] base_addr,
    input  logic        data_stb,
    input  logic [7:0]  rx_byte,
    output logic        wr_req,
    output logic [31:0] wr_addr,
    output logic [3:0]  wr_be,
    output logic [31:0] wr_data,
    output logic        err_pulse
);
    logic [31:0] cur;
    logic [2:0]  pos;
    logic [55:0] sh;
    logic        hi_pend;
    logic [31:0] hi_addr;
    logic [31:0] hi_data;
    logic [63:0] full;
    logic [2:0]  last;
    logic [31:0] step;

    // Word assembled from the shifted bytes plus the byte now arriving.
    always_comb begin
        full = {sh, rx_byte};
        last = 3'(kind_bytes(kind) - 4'd1);
        step = 32'(kind_bytes(kind));
    end

    // Byte collection, word commit and the second beat of a double word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            pos       <= '0;
            sh        <= '0;
            hi_pend   <= 1'b0;
            hi_addr   <= '0;
            hi_data   <= '0;
            wr_req    <= 1'b0;
            wr_addr   <= '0;
            wr_be     <= '0;
            wr_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            wr_req    <= 1'b0;
            err_pulse <= 1'b0;
            if (hi_pend) begin
                wr_req  <= 1'b1;
                wr_addr <= hi_addr;
                wr_be   <= 4'hF;
                wr_data <= hi_data;
                hi_pend <= 1'b0;
            end
            if (!frame_act) begin
                pos <= '0;
            end else if (addr_done && active) begin
                cur <= base_addr;
                pos <= '0;
            end else if (data_stb && active) begin
                sh <= full[55:0];
                if (pos == last) begin
                    pos <= '0;
                    cur <= cur + step;
                    case (kind)
                        K_HALF: begin
                            if (in_window(cur, WIN_LO, WIN_HI)) begin
                                wr_req  <= 1'b1;
                                wr_addr <= {cur[31:2], 2'b00};
                                wr_be   <= cur[1] ? 4'b1100 : 4'b0011;
                                wr_data <= {full[15:0], full[15:0]};
                            end else begin
                                err_pulse <= 1'b1;
                            end
                        end
                        K_WORD: begin
                            wr_req  <= 1'b1;
                            wr_addr <= {cur[31:2], 2'b00};
                            wr_be   <= 4'hF;
                            wr_data <= full[31:0];
                        end
                        default: begin
                            wr_req  <= 1'b1;
                            wr_addr <= {cur[31:2], 2'b00};
                            wr_be   <= 4'hF;
                            wr_data <= full[31:0];
                            hi_pend <= 1'b1;
                            hi_addr <= {cur[31:2], 2'b00} + 32'd4;
                            hi_data <= full[63:32];
                        end
                    endcase
                end else begin
                    pos <= pos + 3'd1;
                end
            end
        end
    end

    // R5: a half write only ever enables one lane pair
    p_half_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kind == K_HALF) |-> (wr_be == 4'b0011 || wr_be == 4'b1100));

    // R11: no half write leaves the legal window
    p_half_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kind == K_HALF) |-> in_window(wr_addr, WIN_LO, WIN_HI));

    // R6: the low half of a double word is followed at once by the high half
    p_burst_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && kind == K_BURST && !wr_addr[2]) |=> (wr_req && wr_addr[2]));

endmodule

// File: rtl/spib_rd_path.sv
// Read path: fetches the memory word or words behind the current address into
// a 64-bit shift buffer, in wire order, and presents its top byte to the host.
// After the last byte of a word it advances the address and refetches.
// Assumes: memory data arrives the cycle after a read request, and data
// strobes are at least 5 cycles apart, so a fetch finishes in time.
module spib_rd_path
    import spib_pkg::*;
#(
    parameter logic [31:0] WIN_LO = 32'h1802_0000,
    parameter logic [31:0] WIN_HI = 32'h1802_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_act,
    input  logic        active,
    input  xfer_kind_t  kind,
    input  logic        addr_done,
    input  logic [31:0] base_addr,
    input  logic        data_stb,
    input  logic [31:0] mem_rdata,
    output logic        rd_req,
    output logic [31:0] rd_addr,
    output logic [7:0]  rd_tx,
    output logic        err_pulse
);
    typedef enum logic [1:0] {F_IDLE, F_A, F_B, F_C} fetch_t;

    fetch_t      st;
    logic [31:0] cur;
    logic [2:0]  pos;
    logic [63:0] rbuf;
    logic [2:0]  last;
    logic [31:0] step;
    logic        blocked;

    // Per-word constants and the half-window block.
    always_comb begin
        last    = 3'(kind_bytes(kind) - 4'd1);
        step    = 32'(kind_bytes(kind));
        blocked = (kind == K_HALF) && !in_window(cur, WIN_LO, WIN_HI);
        rd_tx   = rbuf[63:56];
    end

    // Memory request: upper word of a double first, then the base word.
    always_comb begin
        rd_req  = active && frame_act &&
                  (((st == F_A) && !blocked) || ((st == F_B) && (kind == K_BURST)));
        rd_addr = ((st == F_A) && (kind == K_BURST)) ? ({cur[31:2], 2'b00} + 32'd4)
                                                     : {cur[31:2], 2'b00};
    end

    // Fetch sequencing and byte shifting toward the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= F_IDLE;
            cur       <= '0;
            pos       <= '0;
            rbuf      <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (!frame_act) begin
                st  <= F_IDLE;
                pos <= '0;
            end else if (addr_done && active) begin
                cur <= base_addr;
                pos <= '0;
                st  <= F_A;
            end else if (data_stb && active) begin
                rbuf <= {rbuf[55:0], 8'h00};
                if (pos == last) begin
                    pos <= '0;
                    cur <= cur + step;
                    st  <= F_A;
                end else begin
                    pos <= pos + 3'd1;
                end
            end else begin
                case (st)
                    F_A: begin
                        if (blocked) begin
                            rbuf      <= '0;
                            err_pulse <= 1'b1;
                            st        <= F_IDLE;
                        end else begin
                            st <= F_B;
                        end
                    end
                    F_B: begin
                        if (kind == K_BURST) begin
                            rbuf[63:32] <= mem_rdata;
                            st          <= F_C;
                        end else begin
                            if (kind == K_HALF)
                                rbuf[63:32] <= cur[1] ? {mem_rdata[31:16], 16'h0}
                                                      : {mem_rdata[15:0], 16'h0};
                            else
                                rbuf[63:32] <= mem_rdata;
                            st <= F_IDLE;
                        end
                    end
                    F_C: begin
                        rbuf[31:0] <= mem_rdata;
                        st         <= F_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: a half read never reaches memory outside the window
    p_half_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && kind == K_HALF) |-> in_window(cur, WIN_LO, WIN_HI));

endmodule

// File: rtl/spi_mem_bridge.sv
// SPI memory bridge target, top level. It joins the frame decoder with the
// write and read paths, shares the single memory port between them, gates the
// byte returned to the host, and keeps the half-window error flag.
// Assumes: only one direction is active per frame; see the path headers for timing.
module spi_mem_bridge
    import spib_pkg::*;
#(
    parameter int          BURST_MAX = 240,
    parameter logic [31:0] WIN_LO    = 32'h1802_0000,
    parameter logic [31:0] WIN_HI    = 32'h1802_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_act,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        win_err
);
    xfer_kind_t  kind;
    logic        is_write;
    logic [31:0] base_addr;
    logic        addr_done;
    logic        cmd_start;
    logic        in_data;
    logic        data_ok;
    logic        data_stb;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic        wr_err;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [7:0]  rd_tx;
    logic        rd_err;

    spib_frame_dec #(.BURST_MAX(BURST_MAX)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .kind      (kind),
        .is_write  (is_write),
        .base_addr (base_addr),
        .addr_done (addr_done),
        .cmd_start (cmd_start),
        .in_data   (in_data),
        .data_ok   (data_ok),
        .data_stb  (data_stb)
    );

    spib_wr_path #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .active    (is_write),
        .kind      (kind),
        .addr_done (addr_done),
        .base_addr (base_addr),
        .data_stb  (data_stb),
        .rx_byte   (rx_byte),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .err_pulse (wr_err)
    );

    spib_rd_path #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .active    (!is_write),
        .kind      (kind),
        .addr_done (addr_done),
        .base_addr (base_addr),
        .data_stb  (data_stb),
        .mem_rdata (mem_rdata),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_tx     (rd_tx),
        .err_pulse (rd_err)
    );

    // Memory port sharing and host byte gating.
    always_comb begin
        mem_req   = wr_req || rd_req;
        mem_we    = wr_req;
        mem_addr  = wr_req ? wr_addr : rd_addr;
        mem_be    = wr_req ? wr_be : 4'hF;
        mem_wdata = wr_req ? wr_data : 32'h0;
        tx_byte   = (in_data && !is_write && data_ok) ? rd_tx : 8'h00;
    end

    // Sticky window error, cleared by each accepted command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                 win_err <= 1'b0;
        else if (cmd_start)         win_err <= 1'b0;
        else if (wr_err || rd_err)  win_err <= 1'b1;
    end

    // R4: the two paths never drive the memory port in the same cycle
    p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    // R12: an accepted command leaves the error flag clear
    p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !win_err);

endmodule

// File: tb/sim_spi_mem_bridge.sv
// Scoreboard bench: driver tasks queue expected memory writes and host bytes,
// and a monitor pops and compares them as the design produces them.
module sim_spi_mem_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_act = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        win_err;

    logic        chk_tx = 1'b0;
    string       tag = "R0";
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    typedef struct packed {
        logic [31:0] a;
        logic [3:0]  be;
        logic [31:0] d;
    } wr_item_t;

    wr_item_t    wq[$];
    logic [7:0]  txq[$];

    always #10 clk = ~clk;

    spi_mem_bridge u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .win_err   (win_err)
    );

    function automatic logic [31:0] mfun(input logic [31:0] a);
        return (a ^ 32'h3C5A_96E1) + {a[15:0], a[31:16]};
    endfunction

    // Synchronous memory model: read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mfun(mem_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares memory writes and host bytes against the queues.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mem_req && mem_we) begin
                if (wq.size() == 0) begin
                    check(1'b0, tag, "unexpected write", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    wr_item_t e;
                    e = wq.pop_front();
                    check(mem_addr == e.a && mem_be == e.be && mem_wdata == e.d, tag,
                          "write addr/data", {mem_addr, mem_wdata}, {e.a, e.d});
                    check(mem_be == e.be, tag, "write enables", 64'(mem_be), 64'(e.be));
                end
            end
            if (rx_valid && chk_tx) begin
                logic [7:0] eb;
                eb = (txq.size() != 0) ? txq.pop_front() : 8'hXX;
                check(tx_byte === eb, tag, "host byte", 64'(tx_byte), 64'(eb));
            end
        end
    end

    task automatic put_byte(input logic [7:0] b, input bit look, input logic [7:0] exp);
        @(negedge clk);
        if (look) txq.push_back(exp);
        rx_byte  = b;
        rx_valid = 1'b1;
        chk_tx   = look;
        @(negedge clk);
        rx_valid = 1'b0;
        chk_tx   = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic open_frame(input logic [7:0] code, input logic [31:0] a);
        @(negedge clk);
        frame_act = 1'b1;
        repeat (2) @(negedge clk);
        put_byte(code, 1'b0, 8'h00);
        for (int i = 3; i >= 0; i--) put_byte(a[8*i +: 8], 1'b0, 8'h00);
    endtask

    task automatic close_frame();
        @(negedge clk);
        frame_act = 1'b0;
        repeat (6) @(negedge clk);
        check(wq.size() == 0, tag, "writes left unissued", 64'(wq.size()), 64'd0);
        check(txq.size() == 0, tag, "host bytes unseen", 64'(txq.size()), 64'd0);
    endtask

    task automatic fillers();
        for (int i = 0; i < 4; i++) put_byte(8'h5A, 1'b1, 8'h00);
    endtask

    task automatic exp_wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        wr_item_t e;
        e.a = a; e.be = be; e.d = d;
        wq.push_back(e);
    endtask

    task automatic exp_word_bytes(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) put_byte(8'h00, 1'b1, w[8*i +: 8]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R12 reset state
        tag = "R12";
        check(win_err == 1'b0, "R12", "err after reset", 64'(win_err), 64'd0);
        check(mem_req == 1'b0, "R12", "idle port after reset", 64'(mem_req), 64'd0);
        check(tx_byte == 8'h00, "R12", "tx after reset", 64'(tx_byte), 64'd0);

        // R4 R2 R9: word write, trailing throwaway byte never written
        tag = "R4";
        exp_wr(32'h1000_0010, 4'hF, 32'h1122_3344);
        open_frame(8'h03, 32'h1000_0010);
        put_byte(8'h11, 0, 0); put_byte(8'h22, 0, 0);
        put_byte(8'h33, 0, 0); put_byte(8'h44, 0, 0);
        put_byte(8'hEE, 0, 0);
        close_frame();

        // R8 R9: two words then three bytes of an unfinished word
        tag = "R8";
        exp_wr(32'h1000_0100, 4'hF, 32'hA1A2_A3A4);
        exp_wr(32'h1000_0104, 4'hF, 32'hB1B2_B3B4);
        open_frame(8'h03, 32'h1000_0100);
        put_byte(8'hA1, 0, 0); put_byte(8'hA2, 0, 0); put_byte(8'hA3, 0, 0); put_byte(8'hA4, 0, 0);
        put_byte(8'hB1, 0, 0); put_byte(8'hB2, 0, 0); put_byte(8'hB3, 0, 0); put_byte(8'hB4, 0, 0);
        tag = "R9";
        put_byte(8'hC1, 0, 0); put_byte(8'hC2, 0, 0); put_byte(8'hC3, 0, 0);
        close_frame();

        // R5: half writes on both lane pairs with increment
        tag = "R5";
        exp_wr(32'h1802_0000, 4'b0011, 32'hABCD_ABCD);
        exp_wr(32'h1802_0000, 4'b1100, 32'h1357_1357);
        open_frame(8'h01, 32'h1802_0000);
        put_byte(8'hAB, 0, 0); put_byte(8'hCD, 0, 0);
        put_byte(8'h13, 0, 0); put_byte(8'h57, 0, 0);
        put_byte(8'hEE, 0, 0);
        close_frame();
        check(win_err == 1'b0, "R5", "err inside window", 64'(win_err), 64'd0);

        // R11: half write at the exclusive upper edge is dropped
        tag = "R11";
        open_frame(8'h01, 32'h1802_1000);
        put_byte(8'h99, 0, 0); put_byte(8'h88, 0, 0);
        put_byte(8'hEE, 0, 0);
        close_frame();
        check(win_err == 1'b1, "R11", "err after half write out of window", 64'(win_err), 64'd1);

        // R12: err cleared by the next accepted command; R6 double write
        tag = "R6";
        exp_wr(32'h2000_0000, 4'hF, 32'h0506_0708);
        exp_wr(32'h2000_0004, 4'hF, 32'h0102_0304);
        exp_wr(32'h2000_0008, 4'hF, 32'h1516_1718);
        exp_wr(32'h2000_000C, 4'hF, 32'h1112_1314);
        open_frame(8'h05, 32'h2000_0000);
        check(win_err == 1'b0, "R12", "err cleared by command", 64'(win_err), 64'd0);
        for (int i = 1; i <= 8; i++) put_byte(8'(i), 0, 0);
        for (int i = 1; i <= 8; i++) put_byte(8'(8'h10 + i), 0, 0);
        put_byte(8'hEE, 0, 0);
        close_frame();

        // R3 R14: word read, fillers return zero
        tag = "R3";
        open_frame(8'h02, 32'h3000_0000);
        fillers();
        tag = "R14";
        exp_word_bytes(mfun(32'h3000_0000));
        exp_word_bytes(mfun(32'h3000_0004));
        close_frame();

        // R14: half read from lane pair 1, then lane pair 0 of the next word
        tag = "R14";
        begin
            logic [31:0] w0, w1;
            w0 = mfun(32'h1802_0000);
            w1 = mfun(32'h1802_0004);
            open_frame(8'h00, 32'h1802_0002);
            fillers();
            put_byte(8'h00, 1, w0[31:24]); put_byte(8'h00, 1, w0[23:16]);
            put_byte(8'h00, 1, w1[15:8]);  put_byte(8'h00, 1, w1[7:0]);
            close_frame();
        end

        // R11: half read below the window returns zeros and flags
        tag = "R11";
        open_frame(8'h00, 32'h1801_FFFC);
        fillers();
        put_byte(8'h00, 1, 8'h00); put_byte(8'h00, 1, 8'h00);
        close_frame();
        check(win_err == 1'b1, "R11", "err after half read out of window", 64'(win_err), 64'd1);

        // R7: double read sends the upper word first
        tag = "R7";
        open_frame(8'h04, 32'h4000_0000);
        fillers();
        exp_word_bytes(mfun(32'h4000_0004));
        exp_word_bytes(mfun(32'h4000_0000));
        exp_word_bytes(mfun(32'h4000_000C));
        exp_word_bytes(mfun(32'h4000_0008));
        close_frame();

        // R10: double write of 248 bytes keeps only the first 240
        tag = "R10";
        for (int w = 0; w < 30; w++) begin
            logic [63:0] v;
            for (int k = 0; k < 8; k++) v[63 - 8*k -: 8] = 8'(8*w + k);
            exp_wr(32'h5000_0000 + 32'(8*w), 4'hF, v[31:0]);
            exp_wr(32'h5000_0004 + 32'(8*w), 4'hF, v[63:32]);
        end
        open_frame(8'h05, 32'h5000_0000);
        for (int i = 0; i < 248; i++) put_byte(8'(i), 0, 0);
        put_byte(8'hEE, 0, 0);
        close_frame();

        // R10: double read of 248 bytes, tail returns zeros
        open_frame(8'h04, 32'h6000_0000);
        fillers();
        for (int i = 0; i < 248; i++) begin
            logic [31:0] w;
            int k;
            k = i % 8;
            w = (k < 4) ? mfun(32'h6000_0004 + 32'(8*(i/8))) : mfun(32'h6000_0000 + 32'(8*(i/8)));
            put_byte(8'h00, 1, (i < 240) ? w[31 - 8*(k%4) -: 8] : 8'h00);
        end
        close_frame();

        // R1: undefined command ignores the whole frame
        tag = "R1";
        open_frame(8'h07, 32'h1000_0000);
        for (int i = 0; i < 8; i++) put_byte(8'h03, 1, 8'h00);
        close_frame();

        // R13: frame dropped inside the address, next frame decodes normally
        tag = "R13";
        @(negedge clk);
        frame_act = 1'b1;
        put_byte(8'h03, 0, 0); put_byte(8'h77, 0, 0); put_byte(8'h66, 0, 0);
        close_frame();
        exp_wr(32'h7000_0020, 4'hF, 32'hCAFE_F00D);
        open_frame(8'h03, 32'h7000_0020);
        put_byte(8'hCA, 0, 0); put_byte(8'hFE, 0, 0); put_byte(8'hF0, 0, 0); put_byte(8'h0D, 0, 0);
        close_frame();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule